// File: doc/BRIEF.md
# Bridge VGA-Aware Address Decoder

This block makes the address-phase claim decision for a transparent PCI-to-PCI bridge. Whenever an address phase is presented with a valid strobe, it looks at the address, the command class (memory or I/O) and the side on which the transaction appeared. From these it decides whether the bridge claims the transaction. A claim on the primary side forwards it downstream; a claim on the secondary side forwards it upstream. It registers that decision together with a reason code one clock later.

Three programmable windows steer ordinary traffic: a memory window, a prefetchable memory window and an I/O window. When legacy VGA support is switched on, a fixed video memory range and a 10-bit aliased video I/O register range take precedence over the windows. These ranges are always pulled downstream and never passed upstream. Only the memory and I/O enable bits gate them. The ISA enable input is present for completeness of the configuration set, but the decode does not use it. There is no palette snooping, so palette register addresses are treated like any other video I/O address.

The design has no sequential control beyond its output register, so there is no state machine. The decision is one combinational stage, `decide`, feeding a single output register stage, `hold`.

Top module: `vga_bridge_decode`

## Requirements
- R1: With `cfg_vga_en`=1 and `cfg_mem_en`=1, a primary-side memory access (`req_is_io`=0, `req_from_sec`=0) at an address from 0x000A0000 to 0x000BFFFF inclusive is claimed with reason 1 (video memory).
- R2: With `cfg_vga_en`=1 and `cfg_io_en`=1, a primary-side I/O access is claimed with reason 2 (video I/O) when address bits [31:16] are zero and bits [9:0] lie in 0x3B0..0x3BB or 0x3C0..0x3DF. If any of bits [31:16] is set, it is not a video I/O match.
- R3: For the video I/O match, address bits [15:10] are ignored, so for example 0x7B0 and 0xBC0 match in the same way as 0x3B0 and 0x3C0.
- R4: A video match is claimed downstream whatever the windows hold. When an address is both a video match and a window match, the reason reported is the video one (1 or 2).
- R5: A secondary-side access is claimed with reason 6 (upstream) only when it lies outside every window of its class and outside the video range of its class while `cfg_vga_en`=1. Otherwise it is not claimed and the reason is 0.
- R6: Every memory claim, from either side and for any reason, requires `cfg_mem_en`=1. Every I/O claim requires `cfg_io_en`=1. A gated access gives claim 0 and reason 0.
- R7: `cfg_isa_en` has no effect on either output.
- R8: Outside the video ranges, a primary memory access is claimed with reason 3 if it lies within [`cfg_mem_base`, `cfg_mem_limit`] inclusive. Failing that, it is claimed with reason 4 if it lies within [`cfg_pf_base`, `cfg_pf_limit`]. A primary I/O access inside [`cfg_io_base`, `cfg_io_limit`] is claimed with reason 5. A window whose limit is below its base matches nothing.
- R9: `claim` and `reason` change only on the clock edge after `req_valid` is sampled. After an edge where `req_valid`=0, they read 0 and reason 0 (none). Both are 0 during and after reset.
- R10: With `cfg_vga_en`=0, the video ranges get no special treatment and are decoded by the windows alone.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Address phase present this cycle |
| req_addr | input | 32 | Transaction address |
| req_is_io | input | 1 | 1 = I/O command, 0 = memory command |
| req_from_sec | input | 1 | 1 = seen on secondary side, 0 = primary side |
| cfg_mem_base | input | 32 | Memory window base, inclusive |
| cfg_mem_limit | input | 32 | Memory window limit, inclusive |
| cfg_pf_base | input | 32 | Prefetchable window base, inclusive |
| cfg_pf_limit | input | 32 | Prefetchable window limit, inclusive |
| cfg_io_base | input | 32 | I/O window base, inclusive |
| cfg_io_limit | input | 32 | I/O window limit, inclusive |
| cfg_vga_en | input | 1 | Legacy video decode enable |
| cfg_isa_en | input | 1 | ISA enable (not used by the decode) |
| cfg_io_en | input | 1 | I/O command enable |
| cfg_mem_en | input | 1 | Memory command enable |
| claim | output | 1 | Registered claim decision |
| reason | output | 3 | 0 none, 1 video mem, 2 video I/O, 3 mem window, 4 prefetch window, 5 I/O window, 6 upstream |

## Verification
The only internal state is the output register, so a wrong decision shows at `claim` and `reason` on the very next edge after the address phase, and nowhere else. Errors in the range arithmetic appear as a missed or spurious claim at a range edge, such as 0x9FFFF, 0xC0000, 0x3BB/0x3BC or 0x3DF/0x3E0. Errors in priority appear as a correct claim carrying the wrong reason code. A fault in the registering shows as outputs that persist into a cycle with no valid strobe.

// File: rtl/vga_bridge_pkg.sv
package vga_bridge_pkg;
    typedef enum logic [2:0] {
        RSN_NONE     = 3'd0,
        RSN_VGA_MEM  = 3'd1,
        RSN_VGA_IO   = 3'd2,
        RSN_MEM_WIN  = 3'd3,
        RSN_PF_WIN   = 3'd4,
        RSN_IO_WIN   = 3'd5,
        RSN_UPSTREAM = 3'd6
    } reason_e;

    localparam int unsigned VID_MEM_LO  = 32'h000A_0000;
    localparam int unsigned VID_MEM_HI  = 32'h000B_FFFF;
    localparam int unsigned VID_IO_A_LO = 10'h3B0;
    localparam int unsigned VID_IO_A_HI = 10'h3BB;
    localparam int unsigned VID_IO_B_LO = 10'h3C0;
    localparam int unsigned VID_IO_B_HI = 10'h3DF;
    localparam int unsigned IO_ALIAS_W  = 10;
    localparam int unsigned IO_SPACE_W  = 16;

    typedef struct packed {
        logic   claim;
        reason_e why;
    } verdict_t;
endpackage

// File: rtl/bdg_window.sv
module bdg_window #(
    parameter int AW = 32
) (
    input  logic [AW-1:0] addr,
    input  logic [AW-1:0] base,
    input  logic [AW-1:0] limit,
    output logic          hit
);
    logic live;
    assign live = (base <= limit);
    assign hit  = live && (addr >= base) && (addr <= limit);
endmodule

// File: rtl/bdg_vga_match.sv
module bdg_vga_match
    import vga_bridge_pkg::*;
#(
    parameter int AW = 32
) (
    input  logic [AW-1:0] addr,
    output logic          mem_hit,
    output logic          io_hit
);
    localparam int HI_W = AW - IO_SPACE_W;

    logic [IO_ALIAS_W-1:0] low;
    logic                  upper_zero;

    assign low        = addr[IO_ALIAS_W-1:0];
    assign upper_zero = (addr[AW-1:IO_SPACE_W] == {HI_W{1'b0}});

    assign mem_hit = (addr >= AW'(VID_MEM_LO)) && (addr <= AW'(VID_MEM_HI));
    assign io_hit  = upper_zero &&
                     (((low >= IO_ALIAS_W'(VID_IO_A_LO)) && (low <= IO_ALIAS_W'(VID_IO_A_HI))) ||
                      ((low >= IO_ALIAS_W'(VID_IO_B_LO)) && (low <= IO_ALIAS_W'(VID_IO_B_HI))));
endmodule

// File: rtl/vga_bridge_decode.sv
module vga_bridge_decode
    import vga_bridge_pkg::*;
#(
    parameter int AW = 32
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          req_valid,
    input  logic [AW-1:0] req_addr,
    input  logic          req_is_io,
    input  logic          req_from_sec,
    input  logic [AW-1:0] cfg_mem_base,
    input  logic [AW-1:0] cfg_mem_limit,
    input  logic [AW-1:0] cfg_pf_base,
    input  logic [AW-1:0] cfg_pf_limit,
    input  logic [AW-1:0] cfg_io_base,
    input  logic [AW-1:0] cfg_io_limit,
    input  logic          cfg_vga_en,
    input  logic          cfg_isa_en,
    input  logic          cfg_io_en,
    input  logic          cfg_mem_en,
    output logic          claim,
    output logic [2:0]    reason
);
    localparam int NWIN  = 3;
    localparam int W_MEM = 0;
    localparam int W_PF  = 1;
    localparam int W_IO  = 2;

    logic [NWIN-1:0][AW-1:0] win_base;
    logic [NWIN-1:0][AW-1:0] win_limit;
    logic [NWIN-1:0]         win_hit;

    assign win_base  = {cfg_io_base,  cfg_pf_base,  cfg_mem_base};
    assign win_limit = {cfg_io_limit, cfg_pf_limit, cfg_mem_limit};

    for (genvar g = 0; g < NWIN; g++) begin : g_win
        bdg_window #(.AW(AW)) win_i (
            .addr  (req_addr),
            .base  (win_base[g]),
            .limit (win_limit[g]),
            .hit   (win_hit[g])
        );
    end

    logic vid_mem_raw, vid_io_raw;
    bdg_vga_match #(.AW(AW)) vid_i (
        .addr    (req_addr),
        .mem_hit (vid_mem_raw),
        .io_hit  (vid_io_raw)
    );

    logic     vid_mem, vid_io;
    logic     isa_unused;
    verdict_t decide;

    assign vid_mem    = cfg_vga_en && vid_mem_raw;
    assign vid_io     = cfg_vga_en && vid_io_raw;
    assign isa_unused = cfg_isa_en;

    always_comb begin
        decide = '{claim: 1'b0, why: RSN_NONE};
        unique case ({req_from_sec, req_is_io})
            2'b00: begin
                if (cfg_mem_en) begin
                    if (vid_mem)             decide = '{1'b1, RSN_VGA_MEM};
                    else if (win_hit[W_MEM]) decide = '{1'b1, RSN_MEM_WIN};
                    else if (win_hit[W_PF])  decide = '{1'b1, RSN_PF_WIN};
                end
            end
            2'b01: begin
                if (cfg_io_en) begin
                    if (vid_io)              decide = '{1'b1, RSN_VGA_IO};
                    else if (win_hit[W_IO])  decide = '{1'b1, RSN_IO_WIN};
                end
            end
            2'b10: begin
                if (cfg_mem_en && !vid_mem && !win_hit[W_MEM] && !win_hit[W_PF])
                    decide = '{1'b1, RSN_UPSTREAM};
            end
            2'b11: begin
                if (cfg_io_en && !vid_io && !win_hit[W_IO])
                    decide = '{1'b1, RSN_UPSTREAM};
            end
            default: decide = '{1'b0, RSN_NONE};
        endcase
    end

    verdict_t hold;
    always_ff @(posedge clk) begin
        if (!rst_n)          hold <= '{1'b0, RSN_NONE};
        else if (req_valid)  hold <= decide;
        else                 hold <= '{1'b0, RSN_NONE};
    end

    assign claim  = hold.claim;
    assign reason = hold.why;
endmodule

// File: rtl/vga_bridge_decode_chk.sv
module vga_bridge_decode_chk #(
    parameter int AW = 32
) (
    input logic          clk,
    input logic          rst_n,
    input logic          req_valid,
    input logic [AW-1:0] req_addr,
    input logic          req_is_io,
    input logic          req_from_sec,
    input logic          cfg_vga_en,
    input logic          cfg_isa_en,
    input logic          cfg_io_en,
    input logic          cfg_mem_en,
    input logic          claim,
    input logic [2:0]    reason
);
    logic in_vmem, in_vio;
    assign in_vmem = (req_addr >= AW'(32'h000A_0000)) && (req_addr <= AW'(32'h000B_FFFF));
    assign in_vio  = (req_addr[AW-1:16] == '0) &&
                     (((req_addr[9:0] >= 10'h3B0) && (req_addr[9:0] <= 10'h3BB)) ||
                      ((req_addr[9:0] >= 10'h3C0) && (req_addr[9:0] <= 10'h3DF)));

    p_vga_mem_down_r1: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid && !req_from_sec && !req_is_io && cfg_vga_en && cfg_mem_en && in_vmem
        |=> claim && reason == 3'd1);

    p_vga_io_down_r2: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid && !req_from_sec && req_is_io && cfg_vga_en && cfg_io_en && in_vio
        |=> claim && reason == 3'd2);

    p_vga_no_upstream_r5: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid && req_from_sec && cfg_vga_en &&
        ((!req_is_io && in_vmem) || (req_is_io && in_vio))
        |=> !claim && reason == 3'd0);

    p_mem_gate_r6: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid && !req_is_io && !cfg_mem_en |=> !claim);

    p_io_gate_r6: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid && req_is_io && !cfg_io_en |=> !claim);

    p_idle_quiet_r9: assert property (@(posedge clk) disable iff (!rst_n)
        !req_valid |=> !claim && reason == 3'd0);

    p_claim_reason_r9: assert property (@(posedge clk) disable iff (!rst_n)
        claim == (reason != 3'd0));

    logic isa_seen;
    assign isa_seen = cfg_isa_en;
endmodule

bind vga_bridge_decode vga_bridge_decode_chk #(.AW(AW)) chk_i (.*);

// File: tb/vga_bridge_decode_tb_top.sv
module vga_bridge_decode_tb_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0;
    logic [31:0] req_addr = '0;
    logic        req_is_io = 1'b0;
    logic        req_from_sec = 1'b0;
    logic [31:0] cfg_mem_base = '0, cfg_mem_limit = '0;
    logic [31:0] cfg_pf_base = '0, cfg_pf_limit = '0;
    logic [31:0] cfg_io_base = '0, cfg_io_limit = '0;
    logic        cfg_vga_en = 1'b0, cfg_isa_en = 1'b0, cfg_io_en = 1'b0, cfg_mem_en = 1'b0;
    logic        claim;
    logic [2:0]  reason;

    int n_run = 0;
    int n_fail = 0;

    always #2.5 clk = ~clk;

    vga_bridge_decode dut_i (.*);

    function automatic logic in_win(input logic [31:0] a, input logic [31:0] b, input logic [31:0] l);
        return (b <= l) && (a >= b) && (a <= l);
    endfunction

    function automatic logic [3:0] model();
        logic vm, vi, mw, pw, iw;
        vm = cfg_vga_en && req_addr >= 32'hA0000 && req_addr <= 32'hBFFFF;
        vi = cfg_vga_en && req_addr[31:16] == 16'h0 &&
             ((req_addr[9:0] >= 10'h3B0 && req_addr[9:0] <= 10'h3BB) ||
              (req_addr[9:0] >= 10'h3C0 && req_addr[9:0] <= 10'h3DF));
        mw = in_win(req_addr, cfg_mem_base, cfg_mem_limit);
        pw = in_win(req_addr, cfg_pf_base, cfg_pf_limit);
        iw = in_win(req_addr, cfg_io_base, cfg_io_limit);
        if (!req_from_sec && !req_is_io) begin
            if (!cfg_mem_en) return 4'h0;
            if (vm) return {1'b1, 3'd1};
            if (mw) return {1'b1, 3'd3};
            if (pw) return {1'b1, 3'd4};
            return 4'h0;
        end
        if (!req_from_sec && req_is_io) begin
            if (!cfg_io_en) return 4'h0;
            if (vi) return {1'b1, 3'd2};
            if (iw) return {1'b1, 3'd5};
            return 4'h0;
        end
        if (!req_is_io) return (cfg_mem_en && !vm && !mw && !pw) ? {1'b1, 3'd6} : 4'h0;
        return (cfg_io_en && !vi && !iw) ? {1'b1, 3'd6} : 4'h0;
    endfunction

    task automatic check(input string tag, input logic [3:0] exp);
        n_run++;
        if ({claim, reason} !== exp) begin
            n_fail++;
            $display("FAIL %s addr=%h io=%0d sec=%0d actual claim=%0d reason=%0d expected claim=%0d reason=%0d",
                     tag, req_addr, req_is_io, req_from_sec, claim, reason, exp[3], exp[2:0]);
        end
    endtask

    // drive at negedge, check at the following negedge (one register stage)
    task automatic issue(input string tag, input logic [31:0] a, input logic io, input logic sec);
        logic [3:0] exp;
        req_addr = a; req_is_io = io; req_from_sec = sec; req_valid = 1'b1;
        exp = model();
        @(posedge clk); @(negedge clk);
        check(tag, exp);
        req_valid = 1'b0;
    endtask

    function automatic string tag_of(input logic [3:0] e);
        case (e[2:0])
            3'd1: return "R1";
            3'd2: return "R2";
            3'd3, 3'd4, 3'd5: return "R8";
            3'd6: return "R5";
            default: return "R6";
        endcase
    endfunction

    initial begin
        #200000;
        n_run++; n_fail++;
        $display("FAIL watchdog expired actual=running expected=done");
        $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

    initial begin
        int unsigned seed = 32'h5EED_0312;
        void'($urandom(seed));
        repeat (3) @(negedge clk);
        check("R9 reset", 4'h0);
        rst_n = 1'b1;
        @(negedge clk);

        cfg_vga_en = 1; cfg_mem_en = 1; cfg_io_en = 1;
        cfg_mem_base = 32'h0010_0000; cfg_mem_limit = 32'h001F_FFFF;
        cfg_pf_base  = 32'h0020_0000; cfg_pf_limit  = 32'h002F_FFFF;
        cfg_io_base  = 32'h0000_1000; cfg_io_limit  = 32'h0000_1FFF;

        // R1 edges
        issue("R1 lo", 32'h000A0000, 0, 0);
        issue("R1 hi", 32'h000BFFFF, 0, 0);
        issue("R1 below", 32'h0009FFFF, 0, 0);
        issue("R1 above", 32'h000C0000, 0, 0);
        // R2 edges
        issue("R2 3B0", 32'h3B0, 1, 0);
        issue("R2 3BB", 32'h3BB, 1, 0);
        issue("R2 3BC", 32'h3BC, 1, 0);
        issue("R2 3DF", 32'h3DF, 1, 0);
        issue("R2 3E0", 32'h3E0, 1, 0);
        issue("R2 upper", 32'h000103C0, 1, 0);
        // R3 aliasing
        issue("R3 7B0", 32'h7B0, 1, 0);
        issue("R3 BC0", 32'hBC0, 1, 0);
        issue("R3 FFDF", 32'hFFDF, 1, 0);
        // R4 overlap: windows cover VGA
        cfg_mem_base = 32'h0; cfg_mem_limit = 32'h000FFFFF;
        issue("R4 mem overlap", 32'h000A8000, 0, 0);
        cfg_io_base = 32'h0; cfg_io_limit = 32'hFFFF;
        issue("R4 io overlap", 32'h3C4, 1, 0);
        issue("R8 io win", 32'h3A0, 1, 0);
        // R5 upstream
        issue("R5 sec vga mem", 32'h000B0000, 0, 1);
        issue("R5 sec in win", 32'h00050000, 0, 1);
        issue("R5 sec outside", 32'h40000000, 0, 1);
        issue("R5 sec vga io", 32'h3D4, 1, 1);
        issue("R5 sec io out", 32'h00020000, 1, 1);
        // R8 inclusive / priority / inverted
        cfg_mem_base = 32'h100000; cfg_mem_limit = 32'h1FFFFF;
        cfg_pf_base  = 32'h180000; cfg_pf_limit  = 32'h2FFFFF;
        issue("R8 mem base", 32'h100000, 0, 0);
        issue("R8 mem limit", 32'h1FFFFF, 0, 0);
        issue("R8 both", 32'h180000, 0, 0);
        issue("R8 pf limit", 32'h2FFFFF, 0, 0);
        cfg_pf_base = 32'h300000; cfg_pf_limit = 32'h200000;
        issue("R8 inverted", 32'h280000, 0, 0);
        issue("R8 inverted sec", 32'h280000, 0, 1);
        // R6 gating
        cfg_mem_en = 0;
        issue("R6 vga mem gated", 32'h000A0000, 0, 0);
        issue("R6 up mem gated", 32'h40000000, 0, 1);
        cfg_mem_en = 1; cfg_io_en = 0;
        issue("R6 vga io gated", 32'h3C0, 1, 0);
        cfg_io_en = 1;
        // R10
        cfg_vga_en = 0;
        issue("R10 mem", 32'h000A0000, 0, 0);
        issue("R10 io", 32'h3B0, 1, 0);
        issue("R10 sec mem", 32'h000A0000, 0, 1);
        cfg_vga_en = 1;
        // R7 ISA toggle
        cfg_isa_en = 1;
        issue("R7 isa mem", 32'h000A0000, 0, 0);
        issue("R7 isa io", 32'h7C0, 1, 0);
        cfg_isa_en = 0;
        // R9 idle after valid
        issue("R9 prime", 32'h000A0000, 0, 0);
        @(posedge clk); @(negedge clk);
        check("R9 idle", 4'h0);

        // random
        for (int i = 0; i < 3000; i++) begin
            logic [31:0] a;
            logic [3:0]  e;
            int k;
            k = $urandom_range(0, 4);
            case (k)
                0: a = 32'h0009F000 + $urandom_range(0, 32'h22000);
                1: a = {$urandom_range(0, 3) == 0 ? 16'h1 : 16'h0, 16'($urandom)};
                2: a = $urandom_range(0, 32'h00400000);
                3: a = $urandom;
                default: a = {22'h0, 10'($urandom_range(10'h3A8, 10'h3E8))} | (32'($urandom_range(0, 63)) << 10);
            endcase
            cfg_vga_en   = ($urandom_range(0, 3) != 0);
            cfg_isa_en   = 1'($urandom);
            cfg_mem_en   = ($urandom_range(0, 5) != 0);
            cfg_io_en    = ($urandom_range(0, 5) != 0);
            cfg_mem_base = $urandom_range(0, 32'h200000);
            cfg_mem_limit= $urandom_range(0, 32'h300000);
            cfg_pf_base  = $urandom_range(0, 32'h300000);
            cfg_pf_limit = $urandom_range(0, 32'h400000);
            cfg_io_base  = $urandom_range(0, 32'h8000);
            cfg_io_limit = $urandom_range(0, 32'h10000);
            req_addr = a; req_is_io = 1'($urandom); req_from_sec = 1'($urandom);
            e = model();
            issue(tag_of(e), a, req_is_io, req_from_sec);
        end

        $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end
endmodule